// File: doc/BRIEF.md
# Dual-Mode Host Bus Slave

This block is the slave end of a 16-bit host processor bus. The host reaches either a bank of internal registers or an external memory port through it. A static strap input picks the handshake style. In split-strobe style the host uses separate active-low read and write strobes, and the block answers on an actively driven ready line. In data-strobe style the host uses one active-low data strobe together with a direction line, and the block answers with an active-low acknowledge that is driven only briefly, like an open-drain output.

Chip select, the data strobe or strobes, the direction line, the memory-select line and the 20-bit word address all pass through two-flop synchronisers before decoding. Each access issues exactly one one-cycle request: a register write pulse, a register read pulse, or a memory request. Address and write data are held on shared outputs for that request. The block answers after a fixed latency for registers, and after the memory port's completion pulse for memory. The pad drivers are left to the chip level. The ready line and the interrupt line each come out as a value plus an output enable. The interrupt enable pulls the interrupt pin low whenever a pending source is also enabled.

Top module: `hbi_top`

## Requirements
- R1: With `mode_sep_i` high, `wr_rw_i` is an active-low write strobe and `rd_ds_n_i` is an active-low read strobe. With `mode_sep_i` low, `rd_ds_n_i` is an active-low data strobe and `wr_rw_i` gives the direction (1 = read, 0 = write). In that mode, toggling `wr_rw_i` without the data strobe starts nothing.
- R2: While `cs_n_i` is high no access starts: no request pulse ever appears for a strobe given with chip select high.
- R3: An access with `mem_sel_i` high raises `mem_req_o` (with `mem_we_o` high for a write). With `mem_sel_i` low it raises `reg_wr_o` or `reg_rd_o`. At most one of the three is high in any cycle.
- R4: An access produces exactly one one-cycle request pulse. The pulse is visible after the third rising clock edge that sees the strobe and chip select asserted (two synchroniser stages plus launch). All outputs are inactive during reset.
- R5: During the request pulse, `acc_addr_o` carries the 20-bit word address and `acc_wdata_o` carries the write data. For a read, `rdata_o` returns the value captured from `reg_rdata_i` or `mem_rdata_i`.
- R6: For a register access the acknowledge is presented two cycles after the request pulse. `reg_rdata_i` is sampled in the cycle after the read pulse.
- R7: For a memory access the acknowledge is held off until `mem_done_i` is seen high at a clock edge, and is presented in the following cycle. `mem_rdata_i` is sampled at that same edge.
- R8: In split-strobe mode `rdy_oe_o` equals NOT `cs_n_i`. While enabled, `rdy_o` is low from strobe assertion until the acknowledge and high otherwise.
- R9: In data-strobe mode the acknowledge drives `rdy_oe_o`=1, `rdy_o`=0 until the synchronised strobe is released. It then drives `rdy_o`=1 for one cycle and then sets `rdy_oe_o`=0.
- R10: `data_oe_o` is high only while chip select is low, the read strobe (or data strobe with direction = read) is asserted and an access is in progress. It drops in the same cycle the strobe or chip select is removed.
- R11: `irq_oe_o` (drive the active-low interrupt pin low) is high in the cycle after any bit of `irq_pend_i & irq_en_i` is set, and low in the cycle after none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sep_i | input | 1 | Strap: 1 = split strobes, 0 = data strobe plus direction |
| cs_n_i | input | 1 | Chip select, active low |
| wr_rw_i | input | 1 | Write strobe (active low) or direction line (1 = read) |
| rd_ds_n_i | input | 1 | Read strobe or data strobe, active low |
| mem_sel_i | input | 1 | 1 = external memory, 0 = internal registers |
| addr_i | input | 20 | Word address, host address bits 20..1 |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data |
| data_oe_o | output | 1 | Host data bus output enable |
| rdy_o | output | 1 | Ready / acknowledge value |
| rdy_oe_o | output | 1 | Ready / acknowledge output enable |
| irq_oe_o | output | 1 | Pull interrupt pin low when high |
| reg_wr_o | output | 1 | Register write pulse |
| reg_rd_o | output | 1 | Register read pulse |
| mem_req_o | output | 1 | Memory request pulse |
| mem_we_o | output | 1 | Memory request is a write |
| acc_addr_o | output | 20 | Latched access address |
| acc_wdata_o | output | 16 | Latched write data |
| reg_rdata_i | input | 16 | Register read data |
| mem_rdata_i | input | 16 | Memory read data |
| mem_done_i | input | 1 | Memory completion pulse |
| irq_pend_i | input | 8 | Pending interrupt sources |
| irq_en_i | input | 8 | Interrupt source enables |

## Verification
A wrong access state shows at the ports within one cycle. It appears as a missing or doubled request pulse, or as an acknowledge that comes a cycle early or late against the fixed register latency or the memory completion edge. A state that fails to return to idle leaves the data-strobe acknowledge stuck driven, or stops the next access from ever being acknowledged. Both are visible on the next host strobe. A stale read-data capture shows as a wrong `rdata_o` at the acknowledge. Interrupt mistakes show one cycle after the pending or enable inputs change.

// File: rtl/hbi_pkg.sv
// Shared types for the host bus slave.
// Assumes: one clock domain for all internal logic.
package hbi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REG1,
        ST_REG2,
        ST_MEMW,
        ST_ACK,
        ST_REL
    } hbi_state_e;
endpackage

// File: rtl/hbi_sync.sv
// Two-flop synchroniser for a bundle of asynchronous host pins.
// Assumes: multi-bit fields (address) are stable well before the strobe is
// recognised, so per-bit skew between stages is harmless.
module hbi_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/hbi_ctrl.sv
// Access sequencer: decodes synchronised host pins, issues one request pulse
// per access, waits the register latency or memory completion, then holds
// the acknowledge until the host strobe is released.
// Assumes: mode_sep_i is static while out of reset.
module hbi_ctrl #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sep_i,
    input  logic              cs_n_s,
    input  logic              wr_rw_s,
    input  logic              rd_ds_n_s,
    input  logic              mem_sel_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_done_i,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [DATA_W-1:0] acc_wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ack_o,
    output logic              rel_o,
    output logic              busy_o
);
    import hbi_pkg::*;

    hbi_state_e state;
    logic       act_s;
    logic       is_wr_s;

    // Decode a pending access from the synchronised pins for the chosen style.
    always_comb begin
        is_wr_s = !wr_rw_s;
        if (mode_sep_i) begin
            act_s = !cs_n_s && (!wr_rw_s || !rd_ds_n_s);
        end else begin
            act_s = !cs_n_s && !rd_ds_n_s;
        end
    end

    // Access state machine with one-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            reg_wr_o    <= 1'b0;
            reg_rd_o    <= 1'b0;
            mem_req_o   <= 1'b0;
            mem_we_o    <= 1'b0;
            acc_addr_o  <= '0;
            acc_wdata_o <= '0;
            rdata_o     <= '0;
        end else begin
            reg_wr_o  <= 1'b0;
            reg_rd_o  <= 1'b0;
            mem_req_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (act_s) begin
                        acc_addr_o  <= addr_s;
                        acc_wdata_o <= wdata_i;
                        mem_we_o    <= is_wr_s;
                        if (mem_sel_s) begin
                            mem_req_o <= 1'b1;
                            state     <= ST_MEMW;
                        end else begin
                            reg_wr_o <= is_wr_s;
                            reg_rd_o <= !is_wr_s;
                            state    <= ST_REG1;
                        end
                    end
                end
                ST_REG1: state <= ST_REG2;
                ST_REG2: begin
                    if (!mem_we_o) rdata_o <= reg_rdata_i;
                    state <= ST_ACK;
                end
                ST_MEMW: begin
                    if (mem_done_i) begin
                        if (!mem_we_o) rdata_o <= mem_rdata_i;
                        state <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (!act_s) state <= ST_REL;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Phase flags consumed by the pad-side logic.
    always_comb begin
        ack_o  = (state == ST_ACK);
        rel_o  = (state == ST_REL);
        busy_o = (state != ST_IDLE);
    end
endmodule

// File: rtl/hbi_irq.sv
// Interrupt combiner: registers the OR of enabled pending sources into the
// enable of the open-drain, active-low interrupt pad.
// Assumes: pending and enable vectors are synchronous to clk.
module hbi_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    output logic         irq_oe_o
);
    logic [N-1:0] live;

    // Per-source masking.
    always_comb live = pend_i & en_i;

    // Registered pad enable, released when nothing enabled is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_oe_o <= 1'b0;
        else        irq_oe_o <= |live;
    end
endmodule

// File: rtl/hbi_top.sv
// Dual-mode host bus slave top: synchronises the host pins, sequences the
// access, and forms the ready/acknowledge and data bus enables.
// Assumes: mode_sep_i is a strap, changed only under reset; pads are built
// outside from the value/enable pairs.
module hbi_top #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int IRQ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sep_i,
    input  logic              cs_n_i,
    input  logic              wr_rw_i,
    input  logic              rd_ds_n_i,
    input  logic              mem_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              data_oe_o,
    output logic              rdy_o,
    output logic              rdy_oe_o,
    output logic              irq_oe_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [DATA_W-1:0] acc_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_done_i,
    input  logic [IRQ_W-1:0]  irq_pend_i,
    input  logic [IRQ_W-1:0]  irq_en_i
);
    localparam int          SYNC_W   = ADDR_W + 4;
    localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, {(ADDR_W + 1){1'b0}}};

    logic [SYNC_W-1:0] pins_raw;
    logic [SYNC_W-1:0] pins_s;
    logic              ack, rel, busy;
    logic              raw_act, raw_rd;

    // Bundle the host pins for synchronisation.
    always_comb pins_raw = {cs_n_i, wr_rw_i, rd_ds_n_i, mem_sel_i, addr_i};

    hbi_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    hbi_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sep_i  (mode_sep_i),
        .cs_n_s      (pins_s[SYNC_W-1]),
        .wr_rw_s     (pins_s[SYNC_W-2]),
        .rd_ds_n_s   (pins_s[SYNC_W-3]),
        .mem_sel_s   (pins_s[SYNC_W-4]),
        .addr_s      (pins_s[ADDR_W-1:0]),
        .wdata_i     (wdata_i),
        .reg_rdata_i (reg_rdata_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_done_i  (mem_done_i),
        .reg_wr_o    (reg_wr_o),
        .reg_rd_o    (reg_rd_o),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .acc_addr_o  (acc_addr_o),
        .acc_wdata_o (acc_wdata_o),
        .rdata_o     (rdata_o),
        .ack_o       (ack),
        .rel_o       (rel),
        .busy_o      (busy)
    );

    hbi_irq #(.N(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (irq_pend_i),
        .en_i     (irq_en_i),
        .irq_oe_o (irq_oe_o)
    );

    // Unsynchronised pin decode so enables drop in the cycle the host lets go.
    always_comb begin
        raw_act = !cs_n_i && (mode_sep_i ? (!wr_rw_i || !rd_ds_n_i) : !rd_ds_n_i);
        raw_rd  = !cs_n_i && !rd_ds_n_i && wr_rw_i;
    end

    // Data bus enable: read in progress with the host still strobing.
    always_comb data_oe_o = raw_rd && busy;

    // Ready (driven) or acknowledge (pseudo open drain) per strap.
    always_comb begin
        if (mode_sep_i) begin
            rdy_oe_o = !cs_n_i;
            rdy_o    = ack || !raw_act;
        end else begin
            rdy_oe_o = ack || rel;
            rdy_o    = rel;
        end
    end
endmodule

// File: rtl/hbi_chk.sv
// Protocol checker for hbi_top, attached by bind.
module hbi_chk #(
    parameter int IRQ_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_sep_i,
    input logic             cs_n_i,
    input logic             reg_wr_o,
    input logic             reg_rd_o,
    input logic             mem_req_o,
    input logic             rdy_o,
    input logic             rdy_oe_o,
    input logic             data_oe_o,
    input logic             irq_oe_o,
    input logic [IRQ_W-1:0] irq_pend_i,
    input logic [IRQ_W-1:0] irq_en_i
);
    logic any_req;
    always_comb any_req = reg_wr_o || reg_rd_o || mem_req_o;

    AST_CS_GATE: assert property (@(posedge clk) disable iff (!rst_n) any_req |-> !$past(cs_n_i, 3)); // R2
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({reg_wr_o, reg_rd_o, mem_req_o})); // R3
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) any_req |=> !any_req); // R4
    AST_REG_LAT: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr_o || reg_rd_o) |-> ##2 (mode_sep_i || (rdy_oe_o && !rdy_o))); // R6
    AST_RDY_TRI: assert property (@(posedge clk) disable iff (!rst_n) (mode_sep_i && cs_n_i) |-> !rdy_oe_o); // R8
    AST_DTACK_REL: assert property (@(posedge clk) disable iff (!rst_n) (!mode_sep_i && rdy_oe_o && rdy_o) |=> !rdy_oe_o); // R9
    AST_DOE_CS: assert property (@(posedge clk) disable iff (!rst_n) data_oe_o |-> !cs_n_i); // R10
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n) (|(irq_pend_i & irq_en_i)) |=> irq_oe_o); // R11
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n) !(|(irq_pend_i & irq_en_i)) |=> !irq_oe_o); // R11
endmodule

bind hbi_top hbi_chk #(.IRQ_W(IRQ_W)) u_hbi_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sep_i (mode_sep_i),
    .cs_n_i     (cs_n_i),
    .reg_wr_o   (reg_wr_o),
    .reg_rd_o   (reg_rd_o),
    .mem_req_o  (mem_req_o),
    .rdy_o      (rdy_o),
    .rdy_oe_o   (rdy_oe_o),
    .data_oe_o  (data_oe_o),
    .irq_oe_o   (irq_oe_o),
    .irq_pend_i (irq_pend_i),
    .irq_en_i   (irq_en_i)
);

// File: tb/hbi_top_bench.sv
`timescale 1ns/1ps
module hbi_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sep_i = 1'b1;
    logic        cs_n_i = 1'b1, wr_rw_i = 1'b1, rd_ds_n_i = 1'b1, mem_sel_i = 1'b0;
    logic [19:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o, acc_wdata_o, reg_rdata_i, mem_rdata_i;
    logic [19:0] acc_addr_o;
    logic        data_oe_o, rdy_o, rdy_oe_o, irq_oe_o;
    logic        reg_wr_o, reg_rd_o, mem_req_o, mem_we_o;
    logic        mem_done_i = 1'b0;
    logic [7:0]  irq_pend_i = '0, irq_en_i = '0;

    int checks = 0;
    int errors = 0;
    int mem_delay = 3;
    int mcnt = 0;
    logic [19:0] exp_addr = '0;
    logic [15:0] exp_wd = '0;
    bit          exp_wr = 1'b0;

    always #2 clk = ~clk;

    hbi_top u_hbi_top (
        .clk(clk), .rst_n(rst_n), .mode_sep_i(mode_sep_i), .cs_n_i(cs_n_i),
        .wr_rw_i(wr_rw_i), .rd_ds_n_i(rd_ds_n_i), .mem_sel_i(mem_sel_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .data_oe_o(data_oe_o),
        .rdy_o(rdy_o), .rdy_oe_o(rdy_oe_o), .irq_oe_o(irq_oe_o),
        .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .acc_addr_o(acc_addr_o), .acc_wdata_o(acc_wdata_o),
        .reg_rdata_i(reg_rdata_i), .mem_rdata_i(mem_rdata_i), .mem_done_i(mem_done_i),
        .irq_pend_i(irq_pend_i), .irq_en_i(irq_en_i)
    );

    // Register file and memory stand-ins: data derived from the address.
    assign reg_rdata_i = acc_addr_o[15:0] ^ 16'h5A3C;
    assign mem_rdata_i = ~acc_addr_o[15:0];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory responder: done pulse mem_delay cycles after each request.
    always @(negedge clk) begin
        mem_done_i = 1'b0;
        if (mem_req_o) mcnt = mem_delay;
        else if (mcnt > 0) begin
            mcnt--;
            if (mcnt == 0) mem_done_i = 1'b1;
        end
    end

    // Cycle-by-cycle reference model and comparison.
    logic [23:0] ms1, ms2;
    int  ph = 0;
    bit  e_wr, e_rd, e_mem, e_irq;
    always @(posedge clk) begin
        bit act, raw_act, raw_rd, e_oe, e_rdy;
        if (!rst_n) begin
            ms1 = 24'hE00000; ms2 = 24'hE00000; ph = 0;
            e_wr = 0; e_rd = 0; e_mem = 0; e_irq = 0;
        end else begin
            act = !ms2[23] && (mode_sep_i ? (!ms2[22] || !ms2[21]) : !ms2[21]);
            e_wr = 0; e_rd = 0; e_mem = 0;
            case (ph)
                0: if (act) begin
                       if (ms2[20]) begin e_mem = 1; ph = 3; end
                       else begin
                           if (!ms2[22]) e_wr = 1; else e_rd = 1;
                           ph = 1;
                       end
                   end
                1: ph = 2;
                2: ph = 4;
                3: if (mem_done_i) ph = 4;
                4: if (!act) ph = 5;
                default: ph = 0;
            endcase
            e_irq = |(irq_pend_i & irq_en_i);
            ms2 = ms1;
            ms1 = {cs_n_i, wr_rw_i, rd_ds_n_i, mem_sel_i, addr_i};
        end
        #1;
        if (!rst_n) begin
            chk(!(reg_wr_o || reg_rd_o || mem_req_o || irq_oe_o || data_oe_o), "R4 reset idle",
                {reg_wr_o, reg_rd_o, mem_req_o, irq_oe_o, data_oe_o}, 0);
        end else begin
            raw_act = !cs_n_i && (mode_sep_i ? (!wr_rw_i || !rd_ds_n_i) : !rd_ds_n_i);
            raw_rd  = !cs_n_i && !rd_ds_n_i && wr_rw_i;
            chk(reg_wr_o == e_wr, "R1/R3 reg_wr", reg_wr_o, e_wr);
            chk(reg_rd_o == e_rd, "R4/R3 reg_rd", reg_rd_o, e_rd);
            chk(mem_req_o == e_mem, "R3 mem_req", mem_req_o, e_mem);
            if (reg_wr_o || reg_rd_o || mem_req_o) begin
                chk(acc_addr_o == exp_addr, "R5 address", acc_addr_o, exp_addr);
                if (exp_wr) chk(acc_wdata_o == exp_wd, "R5 wdata", acc_wdata_o, exp_wd);
                if (mem_req_o) chk(mem_we_o == exp_wr, "R3 mem_we", mem_we_o, exp_wr);
            end
            if (mode_sep_i) begin
                e_oe = !cs_n_i; e_rdy = (ph == 4) || !raw_act;
                chk(rdy_oe_o == e_oe, "R8 ready enable", rdy_oe_o, e_oe);
                if (e_oe) chk(rdy_o == e_rdy, "R8/R6/R7 ready", rdy_o, e_rdy);
            end else begin
                e_oe = (ph == 4) || (ph == 5); e_rdy = (ph == 5);
                chk(rdy_oe_o == e_oe, "R9/R6/R7 ack enable", rdy_oe_o, e_oe);
                if (e_oe) chk(rdy_o == e_rdy, "R9 ack level", rdy_o, e_rdy);
            end
            chk(data_oe_o == (raw_rd && ph != 0), "R10 data enable", data_oe_o, raw_rd && ph != 0);
            chk(irq_oe_o == e_irq, "R11 irq", irq_oe_o, e_irq);
        end
    end

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst_n = 1'b0; mode_sep_i = m;
        cs_n_i = 1'b1; wr_rw_i = 1'b1; rd_ds_n_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One host access; with cs_on=0 the strobe is given with chip select high.
    task automatic xfer(input bit wr, input bit mem, input logic [19:0] a,
                        input logic [15:0] d, input bit cs_on);
        bit acked = 0;
        logic [15:0] expd;
        @(negedge clk);
        addr_i = a; mem_sel_i = mem; wdata_i = d; cs_n_i = !cs_on;
        exp_addr = a; exp_wd = d; exp_wr = wr;
        if (mode_sep_i) begin
            if (wr) wr_rw_i = 1'b0; else rd_ds_n_i = 1'b0;
        end else begin
            wr_rw_i = !wr; rd_ds_n_i = 1'b0;
        end
        for (int n = 0; n < 60 && !acked; n++) begin
            @(negedge clk);
            if (cs_on) acked = mode_sep_i ? (rdy_oe_o && rdy_o) : (rdy_oe_o && !rdy_o);
            if (!cs_on && n == 12) n = 60;
        end
        if (cs_on) begin
            chk(acked, "R6/R7 acknowledge seen", acked, 1);
            if (!wr) begin
                expd = mem ? ~a[15:0] : (a[15:0] ^ 16'h5A3C);
                chk(rdata_o == expd, "R5 read data", rdata_o, expd);
                chk(data_oe_o, "R10 data enable at ack", data_oe_o, 1);
            end
        end
        @(negedge clk);
        wr_rw_i = 1'b1; rd_ds_n_i = 1'b1; cs_n_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int m = 1; m >= 0; m--) begin
            do_reset(m[0]);
            mem_delay = 5;
            xfer(1, 0, 20'hABCDE, 16'h1234, 1);   // R1 register write
            xfer(0, 0, 20'h00010, 16'h0000, 1);   // R6 register read
            xfer(1, 1, 20'h0F0F0, 16'hBEEF, 1);   // R7 memory write
            mem_delay = 1;
            xfer(0, 1, 20'h12345, 16'h0000, 1);   // R7 memory read, fast done
            xfer(0, 0, 20'h00001, 16'h0000, 0);   // R2 chip select high
            xfer(1, 1, 20'h00002, 16'h5555, 0);   // R2 chip select high, memory
            xfer(0, 0, 20'hFFFFF, 16'h0000, 1);   // R5 top address
            // R1: direction line alone, no data strobe, starts nothing
            @(negedge clk);
            cs_n_i = 1'b0; wr_rw_i = 1'b0; exp_addr = '0;
            if (!mode_sep_i) begin
                repeat (8) @(negedge clk);
            end
            cs_n_i = 1'b1; wr_rw_i = 1'b1;
            repeat (6) @(negedge clk);
            // R11 interrupt masking
            irq_pend_i = 8'h05; irq_en_i = 8'h04; repeat (3) @(negedge clk);
            irq_en_i = 8'h02; repeat (3) @(negedge clk);
            irq_pend_i = 8'h80; irq_en_i = 8'h80; repeat (3) @(negedge clk);
            irq_pend_i = 8'h00; repeat (3) @(negedge clk);
        end
        summary();
    end
endmodule